// File: doc/BRIEF.md
# I2C Controller SCL Generator with Stretch Detection

This block produces the controller-side clock of an I2C bus one bit at a time. A client asks for a bit by holding a request; the block accepts it with a single-cycle acknowledge and then walks through four counted segments: rise, high, fall and low. During the rise and high segments the clock line is released. During the fall and low segments it is pulled low through an open-drain drive signal. Each segment length comes from a programmed count that is captured when the segment begins.

After the rise count has run out, the block looks at the sampled line. If a target is still holding the clock low, the high count does not start. The block waits, with no time limit, until the line is seen high, and only then counts the high segment. Two strobes guide the data path. One marks the middle of the high segment, where received data is sampled. The other marks the first cycle of the low segment, where the data line may change.

If the request is still present when a low segment ends, the next bit follows without a gap. Dropping the enable never cuts a bit short: the bit in progress finishes, and the block then rests with the line released.

Top module: `i2c_scl_gen`

## Requirements
- R1: Out of reset the line is released (`scl_drive_low_o`=0), and `sample_o`, `change_o` and `bit_ack_o` are 0 while no request is made.
- R2: When idle, `bit_ack_o` is 1 in the same cycle that `en_i` and `bit_req_i` are both 1. While `en_i` is 0, no request is acknowledged and the line stays released.
- R3: With no stretching, the line is released for exactly Re+He cycles, counted from the cycle after the acknowledge.
- R4: If the sampled line is 0 in the last rise cycle, the block waits with the line released. The high count begins in the cycle after the first cycle in which the line reads 1.
- R5: After the high segment, `scl_drive_low_o` is 1 for exactly Fe+Le consecutive cycles.
- R6: `sample_o` pulses exactly once per bit, in high-segment cycle floor(He/2), where the first high cycle is numbered 0.
- R7: `change_o` pulses exactly once per bit, in the first low-segment cycle. That cycle is cycle Fe of the driven-low stretch, numbered from 0.
- R8: If `en_i` and `bit_req_i` are 1 in the last low cycle, `bit_ack_o` is 1 in that cycle and the next bit's rise segment follows at once.
- R9: Deasserting `en_i` during a bit lets that bit finish with its full lengths. The line then stays released and a held request is ignored.
- R10: Each segment length is taken from its count input on the clock edge that starts the segment. A change during the rise segment alters the coming high segment. A change to the low count during the low segment does not alter that segment.
- R11: The effective lengths are Re=max(`t_rise_i`,1), Fe=max(`t_fall_i`,1), Le=max(`t_low_i`,1) and He=max(`t_high_i`,4). Four is the smallest high length that leaves time to notice a stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Allows new bits to start |
| bit_req_i | input | 1 | Request for one bit cycle, held until acknowledged |
| bit_ack_o | output | 1 | Request accepted; the rise segment starts next cycle |
| t_rise_i | input | CNT_W | Rise segment count |
| t_high_i | input | CNT_W | High segment count |
| t_fall_i | input | CNT_W | Fall segment count |
| t_low_i | input | CNT_W | Low segment count |
| scl_i | input | 1 | Sampled bus clock level |
| scl_drive_low_o | output | 1 | 1 pulls the open-drain clock line low |
| sample_o | output | 1 | Mid-high data sample strobe |
| change_o | output | 1 | Start-of-low data change strobe |

## Verification
The acknowledge is combinational and is due in the cycle in which the request is presented. Every other result is due a fixed number of cycles after the acknowledge edge:
- release for Re+He cycles, or for the stretch end plus one plus He when a stretch occurs;
- then drive low for Fe+Le cycles;
- the sample strobe at release offset hs+floor(He/2), where hs is Re, or the stretch end plus one;
- the change strobe at drive-low offset Fe.

The bench counts these offsets at falling edges from the first cycle after the acknowledge. It compares each offset with values computed from the clamped counts and the modelled target hold. It changes count inputs and enable only at falling edges, at chosen segment offsets.

// File: rtl/i2c_scl_gen_pkg.sv
package i2c_scl_gen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RISE = 3'd1,
    ST_WAIT = 3'd2,
    ST_HIGH = 3'd3,
    ST_FALL = 3'd4,
    ST_LOW  = 3'd5
  } scl_st_e;

  localparam int unsigned HIGH_FLOOR = 4;
endpackage

// File: rtl/sclgen_len_sel.sv
module sclgen_len_sel
  import i2c_scl_gen_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned HIGH_MIN = HIGH_FLOOR
) (
  input  scl_st_e          seg_i,
  input  logic [CNT_W-1:0] t_rise_i,
  input  logic [CNT_W-1:0] t_high_i,
  input  logic [CNT_W-1:0] t_fall_i,
  input  logic [CNT_W-1:0] t_low_i,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] FLOOR_HI = CNT_W'(HIGH_MIN);
  localparam logic [CNT_W-1:0] FLOOR_LO = CNT_W'(1);

  logic [CNT_W-1:0] raw;
  logic [CNT_W-1:0] floor_v;

  always_comb begin
    floor_v = FLOOR_LO;
    case (seg_i)
      ST_RISE: raw = t_rise_i;
      ST_HIGH: begin
        raw     = t_high_i;
        floor_v = FLOOR_HI;
      end
      ST_FALL: raw = t_fall_i;
      ST_LOW:  raw = t_low_i;
      default: raw = FLOOR_LO;
    endcase
    len_o = (raw < floor_v) ? floor_v : raw;
  end
endmodule

// File: rtl/sclgen_seg_cnt.sv
module sclgen_seg_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mid_o,
  output logic             zero_o,
  output logic             first_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mid_q, mid_d;
  logic             first_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    mid_d  = mid_q;
    if (load_i) begin
      cnt_d = len_i - CNT_W'(1);
      mid_d = (len_i - CNT_W'(1)) - (len_i >> 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mid_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      mid_q <= mid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) first_q <= 1'b0;
    else         first_q <= load_i;
  end

  assign cnt_o   = cnt_q;
  assign mid_o   = mid_q;
  assign zero_o  = (cnt_q == '0);
  assign first_o = first_q;
endmodule

// File: rtl/sclgen_fsm.sv
module sclgen_fsm
  import i2c_scl_gen_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    req_i,
  input  logic    scl_i,
  input  logic    zero_i,
  output scl_st_e state_o,
  output scl_st_e state_next_o,
  output logic    load_o,
  output logic    accept_o
);
  scl_st_e state_q, state_d;
  logic    go;

  always_comb begin
    go       = en_i && req_i;
    state_d  = state_q;
    accept_o = 1'b0;
    case (state_q)
      ST_IDLE: if (go) begin
        state_d  = ST_RISE;
        accept_o = 1'b1;
      end
      ST_RISE: if (zero_i) state_d = scl_i ? ST_HIGH : ST_WAIT;
      ST_WAIT: if (scl_i)  state_d = ST_HIGH;
      ST_HIGH: if (zero_i) state_d = ST_FALL;
      ST_FALL: if (zero_i) state_d = ST_LOW;
      ST_LOW:  if (zero_i) begin
        if (go) begin
          state_d  = ST_RISE;
          accept_o = 1'b1;
        end else begin
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o      = state_q;
  assign state_next_o = state_d;
  assign load_o       = (state_d != state_q);
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_gen_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned HIGH_MIN = HIGH_FLOOR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_req_i,
  output logic             bit_ack_o,
  input  logic [CNT_W-1:0] t_rise_i,
  input  logic [CNT_W-1:0] t_high_i,
  input  logic [CNT_W-1:0] t_fall_i,
  input  logic [CNT_W-1:0] t_low_i,
  input  logic             scl_i,
  output logic             scl_drive_low_o,
  output logic             sample_o,
  output logic             change_o
);
  scl_st_e          state_q;
  scl_st_e          state_d;
  logic             seg_load;
  logic             seg_zero;
  logic             seg_first;
  logic [CNT_W-1:0] seg_len;
  logic [CNT_W-1:0] seg_cnt;
  logic [CNT_W-1:0] seg_mid;

  sclgen_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .req_i        (bit_req_i),
    .scl_i        (scl_i),
    .zero_i       (seg_zero),
    .state_o      (state_q),
    .state_next_o (state_d),
    .load_o       (seg_load),
    .accept_o     (bit_ack_o)
  );

  sclgen_len_sel #(
    .CNT_W    (CNT_W),
    .HIGH_MIN (HIGH_MIN)
  ) u_len (
    .seg_i    (state_d),
    .t_rise_i (t_rise_i),
    .t_high_i (t_high_i),
    .t_fall_i (t_fall_i),
    .t_low_i  (t_low_i),
    .len_o    (seg_len)
  );

  sclgen_seg_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seg_load),
    .len_i   (seg_len),
    .cnt_o   (seg_cnt),
    .mid_o   (seg_mid),
    .zero_o  (seg_zero),
    .first_o (seg_first)
  );

  assign scl_drive_low_o = (state_q == ST_FALL) || (state_q == ST_LOW);
  assign sample_o        = (state_q == ST_HIGH) && (seg_cnt == seg_mid);
  assign change_o        = (state_q == ST_LOW) && seg_first;
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk
  import i2c_scl_gen_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    en_i,
  input logic    bit_req_i,
  input logic    bit_ack_o,
  input logic    scl_i,
  input logic    scl_drive_low_o,
  input logic    sample_o,
  input logic    change_o,
  input scl_st_e state_q
);
  AST_ACK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_ack_o |-> (en_i && bit_req_i)); // R2

  AST_ACK_THEN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_ack_o |=> !scl_drive_low_o); // R3

  AST_STRETCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !scl_i) |=> (state_q == ST_WAIT && !sample_o)); // R4

  AST_DRIVE_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_drive_low_o) |-> ($past(state_q) == ST_HIGH)); // R5

  AST_SAMPLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !scl_drive_low_o); // R6

  AST_SAMPLE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o); // R6

  AST_CHANGE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |-> (scl_drive_low_o && !sample_o)); // R7

  AST_CHANGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |=> !change_o); // R7
endmodule

bind i2c_scl_gen i2c_scl_gen_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .en_i            (en_i),
  .bit_req_i       (bit_req_i),
  .bit_ack_o       (bit_ack_o),
  .scl_i           (scl_i),
  .scl_drive_low_o (scl_drive_low_o),
  .sample_o        (sample_o),
  .change_o        (change_o),
  .state_q         (state_q)
);

// File: tb/i2c_scl_gen_bench.sv
module i2c_scl_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        req;
  logic        ack;
  logic [15:0] t_r, t_h, t_f, t_l;
  logic        drv;
  logic        smp;
  logic        chg;
  logic        stretch_hold;
  logic        scl_line;
  int          checks   = 0;
  int          failures = 0;

  always #4 clk = ~clk;

  assign scl_line = !(drv || stretch_hold);

  i2c_scl_gen u_i2c_scl_gen (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .en_i            (en),
    .bit_req_i       (req),
    .bit_ack_o       (ack),
    .t_rise_i        (t_r),
    .t_high_i        (t_h),
    .t_fall_i        (t_f),
    .t_low_i         (t_l),
    .scl_i           (scl_line),
    .scl_drive_low_o (drv),
    .sample_o        (smp),
    .change_o        (chg)
  );

  function automatic int eff(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", what, got, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Measures one bit whose first post-acknowledge cycle is the current falling edge.
  task automatic run_body(input int r, input int h, input int f, input int l,
                          input int k, input int h2, input int l2,
                          input bit keep, input bit drop_en);
    int re, he, fe, le, hs;
    int c = 0, rel = 0, low = 0, spos = -1, scnt = 0, cpos = -1, ccnt = 0;
    bit lowseen = 0, done = 0, ackend = 0;
    re = eff(r, 1); he = eff(h2, 4); fe = eff(f, 1); le = eff(l, 1);
    hs = (k <= re - 1) ? re : k + 1;
    while (!done && c < 20000) begin
      stretch_hold = (c < k);
      if (c == 0) begin
        t_h = 16'(h2);
        if (!keep) req = 1'b0;
      end
      if (c == 1 && drop_en) en = 1'b0;
      #1;
      if (!drv) begin
        if (lowseen) done = 1;
        else begin
          rel++;
          if (smp) begin scnt++; spos = c; end
        end
      end else begin
        lowseen = 1;
        if (low == fe) t_l = 16'(l2);
        if (chg) begin ccnt++; cpos = low; end
        if (low == fe + le - 1) ackend = ack;
        low++;
      end
      if (!done) begin c++; @(negedge clk); end
    end
    stretch_hold = 1'b0;
    check("R3/R4 released length", rel, hs + he);
    check("R5/R10 driven-low length", low, fe + le);
    check("R6 sample pulse count", scnt, 1);
    check("R6/R4 sample offset", spos, hs + he / 2);
    check("R7 change pulse count", ccnt, 1);
    check("R7 change offset", cpos, fe);
    if (keep && !drop_en) check("R8 ack on last low cycle", int'(ackend), 1);
  endtask

  task automatic run_bit(input int r, input int h, input int f, input int l,
                         input int k, input int h2, input int l2,
                         input bit keep, input bit drop_en);
    @(negedge clk);
    en  = 1'b1;
    t_r = 16'(r); t_h = 16'(h); t_f = 16'(f); t_l = 16'(l);
    req = 1'b1;
    #1;
    check("R2 ack when idle and enabled", int'(ack), 1);
    @(negedge clk);
    run_body(r, h, f, l, k, h2, l2, keep, drop_en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=1 exp=0");
    summary();
  end

  initial begin
    int seed_v;
    int bad;
    seed_v = int'($urandom(32'h5EED_1234));
    rst_n = 1'b0; en = 1'b0; req = 1'b0; stretch_hold = 1'b0;
    t_r = '0; t_h = '0; t_f = '0; t_l = '0;
    repeat (3) @(negedge clk);
    check("R1 reset drive", int'(drv), 0);
    check("R1 reset strobes", int'(smp | chg | ack), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset drive", int'(drv), 0);

    // R2: disabled, request must be ignored
    req = 1'b1; bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ack || drv) bad++;
    end
    check("R2 no ack while disabled", bad, 0);
    req = 1'b0;

    run_bit(5, 10, 3, 12, 0, 10, 12, 0, 0);  // R3 R5 R6 R7 basic
    run_bit(0, 1, 0, 0, 0, 1, 0, 0, 0);      // R11 clamps
    run_bit(3, 8, 2, 6, 12, 8, 6, 0, 0);     // R4 long stretch
    run_bit(4, 6, 2, 5, 4, 6, 5, 0, 0);      // R4 stretch ends in first wait cycle
    run_bit(4, 6, 2, 9, 0, 14, 3, 0, 0);     // R10 capture at segment start

    // R8 back-to-back bits
    run_bit(3, 5, 2, 4, 0, 5, 4, 1, 0);
    run_body(3, 5, 2, 4, 0, 5, 4, 0, 0);

    // R9 enable dropped mid-bit with request held
    run_bit(4, 7, 3, 5, 0, 7, 5, 1, 1);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      if (ack || drv) bad++;
      @(negedge clk);
    end
    check("R9 idle released after enable drop", bad, 0);
    req = 1'b0;

    for (int n = 0; n < 40; n++) begin
      int r, h, f, l, k, h2, l2;
      r  = int'($urandom_range(1, 20));
      h  = int'($urandom_range(4, 40));
      f  = int'($urandom_range(1, 20));
      l  = int'($urandom_range(1, 40));
      k  = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 40)) : 0;
      h2 = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 30)) : h;
      l2 = int'($urandom_range(0, 40));
      run_bit(r, h, f, l, k, h2, l2, 0, 0);
    end
    summary();
  end
endmodule